// File: doc/BRIEF.md
# Multi-Channel Byte-Serial CRC-16 Engine

This block keeps up to eight independent 16-bit CRC remainders and advances each one by a whole byte per clock. Every channel has its own byte lane and its own valid bit. An accepted byte moves that channel's remainder to the state a bit-serial shift register would reach after eight shifts, with the data fed most significant bit first. A single select input chooses the generator for all channels: either x^16 + x^12 + x^5 + 1 or x^16 + x^15 + x^2 + 1.

The eight-shift update is computed in three dependent steps:
- a term step XORs the upper remainder byte with the incoming byte;
- a sharing step forms, once, the subterms that several output bits reuse;
- a fold step produces the sixteen next-state bits.

All three steps fall inside one clock, so a channel can take a new byte on every cycle. A synchronous clear loads each channel from its own seed word. A per-channel strobe shows which channels took a byte in the previous cycle.

Top module: `crc16_mc_engine`

## Requirements
- R1: After reset, every channel's crc_o field reads 16'hFFFF and every done_o bit is 0.
- R2: When clear_i is high at a rising edge, every channel's remainder takes its seed_i field and done_o stays 0. Clear wins over valid_i, so a byte presented in the same cycle is dropped.
- R3: With poly_sel_i = 0, an accepted byte updates the channel as eight serial shifts of the generator 16'h1021 (x^16 + x^12 + x^5 + 1). Data bit 7 enters first. The new value appears on crc_o in the cycle after the accepting edge.
- R4: With poly_sel_i = 1, an accepted byte updates the channel as eight serial shifts of the generator 16'h8005 (x^16 + x^15 + x^2 + 1). Data bit 7 enters first, and the timing is the same as in R3.
- R5: A channel accepts a byte on every cycle. Back-to-back bytes each build on the state left by the byte before.
- R6: A channel whose valid_i bit is 0 (and clear_i is 0) keeps its remainder unchanged.
- R7: Channel c uses data_i[8c+7:8c], seed_i[16c+15:16c], valid_i[c], crc_o[16c+15:16c] and done_o[c]. Channels do not affect each other.
- R8: done_o[c] is 1 for exactly the cycle after channel c accepted a byte, and 0 otherwise.
- R9: poly_sel_i may change only in a cycle where valid_i is all zero. After a change, later bytes continue from the held remainders under the new generator.
- R10: For the ASCII string "123456789", the engine returns these values:
  - 16'h29B1 with seed FFFF, and 16'h31C3 with seed 0000, under poly_sel_i = 0;
  - 16'hFEE8 with seed 0000, and 16'hAEE7 with seed FFFF, under poly_sel_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous load of all channels from their seeds |
| seed_i | input | 16*N_CH | Per-channel seed words |
| poly_sel_i | input | 1 | 0: x^16+x^12+x^5+1, 1: x^16+x^15+x^2+1 |
| valid_i | input | N_CH | Per-channel byte accept mask |
| data_i | input | 8*N_CH | Per-channel input bytes |
| crc_o | output | 16*N_CH | Per-channel remainders |
| done_o | output | N_CH | Per-channel strobe, one cycle after an accepted byte |

## Verification
Each accepted byte, clear and hold shows on crc_o and done_o exactly one cycle after the edge that sampled it; no output lags further. The bench drives inputs on the falling edge and compares every channel, together with its done bit, at the next falling edge. The expected values come from a bit-serial shift-register model, so each check lands in the single cycle where that result is due. Back-to-back runs, random masks and mode switches between idle cycles are all compared against the same per-cycle model.

// File: rtl/crc16_mc_pkg.sv
package crc16_mc_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;
  localparam int HALF_W = BYTE_W / 2;

  typedef enum logic {
    POLY_CCITT = 1'b0,
    POLY_X15   = 1'b1
  } poly_e;
endpackage

// File: rtl/crc_term_stage.sv
module crc_term_stage
  import crc16_mc_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] term_o
);
  // step 1: upper remainder byte meets the incoming byte
  assign term_o = crc_i[CRC_W-1 -: BYTE_W] ^ byte_i;
endmodule

// File: rtl/crc_share_stage.sv
module crc_share_stage
  import crc16_mc_pkg::*;
(
  input  logic [BYTE_W-1:0] term_i,
  output logic [HALF_W-1:0] fold_o,
  output logic              par_o
);
  // step 2: subterms reused by several output bits
  for (genvar i = 0; i < HALF_W; i++) begin : g_fold
    assign fold_o[i] = term_i[i] ^ term_i[i+HALF_W];
  end
  assign par_o = ^term_i;
endmodule

// File: rtl/crc_fold_stage.sv
module crc_fold_stage
  import crc16_mc_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] term_i,
  input  logic [HALF_W-1:0] fold_i,
  input  logic              par_i,
  input  poly_e             poly_i,
  output logic [CRC_W-1:0]  next_o
);
  logic [BYTE_W-1:0] x;
  assign x = {term_i[BYTE_W-1:HALF_W], fold_i};

  // step 3: remaining bits from old low byte plus step 1/2 terms
  always_comb begin
    next_o = '0;
    if (poly_i == POLY_CCITT) begin
      next_o[3:0] = x[3:0];
      next_o[4]   = x[4];
      next_o[5]   = x[5] ^ x[0];
      next_o[6]   = x[6] ^ x[1];
      next_o[7]   = x[7] ^ x[2];
      next_o[8]   = crc_i[0] ^ x[3];
      next_o[9]   = crc_i[1] ^ x[4];
      next_o[10]  = crc_i[2] ^ x[5];
      next_o[11]  = crc_i[3] ^ x[6];
      next_o[12]  = crc_i[4] ^ x[7] ^ x[0];
      next_o[13]  = crc_i[5] ^ x[1];
      next_o[14]  = crc_i[6] ^ x[2];
      next_o[15]  = crc_i[7] ^ x[3];
    end else begin
      next_o[0] = par_i;
      next_o[1] = par_i ^ term_i[0];
      for (int i = 2; i < BYTE_W; i++) next_o[i] = term_i[i-2] ^ term_i[i-1];
      next_o[8]     = crc_i[0] ^ term_i[6] ^ term_i[7];
      next_o[9]     = crc_i[1] ^ term_i[7];
      next_o[14:10] = crc_i[6:2];
      next_o[15]    = crc_i[7] ^ par_i;
    end
  end
endmodule

// File: rtl/crc_lane.sv
module crc_lane
  import crc16_mc_pkg::*;
#(
  parameter logic [CRC_W-1:0] RST_SEED = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [CRC_W-1:0]  seed_i,
  input  poly_e             poly_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);
  logic [CRC_W-1:0]  crc_q, crc_d;
  logic [BYTE_W-1:0] term;
  logic [HALF_W-1:0] fold;
  logic              par;
  logic              done_q;

  crc_term_stage u_term (.crc_i(crc_q), .byte_i(data_i), .term_o(term));
  crc_share_stage u_share (.term_i(term), .fold_o(fold), .par_o(par));
  crc_fold_stage u_fold (
    .crc_i(crc_q), .term_i(term), .fold_i(fold), .par_i(par),
    .poly_i(poly_i), .next_o(crc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= RST_SEED;
      done_q <= 1'b0;
    end else begin
      done_q <= valid_i & ~clear_i;
      if (clear_i)      crc_q <= seed_i;
      else if (valid_i) crc_q <= crc_d;
    end
  end

  assign crc_o  = crc_q;
  assign done_o = done_q;

  // R2
  clear_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_q == $past(seed_i)) && !done_q);
  // R6
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !valid_i) |=> $stable(crc_q) && !done_q);
  // R3
  ccitt_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && valid_i && poly_i == POLY_CCITT)
      |=> (crc_q[15:13] ^ crc_q[3:1]) == $past(crc_q[7:5]));
  // R4
  x15_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && valid_i && poly_i == POLY_X15)
      |=> crc_q[14:10] == $past(crc_q[6:2]) && (crc_q[15] ^ crc_q[0]) == $past(crc_q[7]));
endmodule

// File: rtl/crc16_mc_engine.sv
module crc16_mc_engine
  import crc16_mc_pkg::*;
#(
  parameter int               N_CH     = 8,
  parameter logic [CRC_W-1:0] RST_SEED = 16'hFFFF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic [N_CH*CRC_W-1:0]   seed_i,
  input  logic                    poly_sel_i,
  input  logic [N_CH-1:0]         valid_i,
  input  logic [N_CH*BYTE_W-1:0]  data_i,
  output logic [N_CH*CRC_W-1:0]   crc_o,
  output logic [N_CH-1:0]         done_o
);
  poly_e poly;
  assign poly = poly_e'(poly_sel_i);

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    crc_lane #(.RST_SEED(RST_SEED)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(clear_i),
      .seed_i (seed_i[c*CRC_W +: CRC_W]),
      .poly_i (poly),
      .valid_i(valid_i[c]),
      .data_i (data_i[c*BYTE_W +: BYTE_W]),
      .crc_o  (crc_o[c*CRC_W +: CRC_W]),
      .done_o (done_o[c])
    );
  end

  // R9
  poly_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|valid_i) |-> $stable(poly_sel_i));
  // R8
  done_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i == '0) |=> done_o == '0);
endmodule

// File: tb/crc16_mc_engine_tb_top.sv
module crc16_mc_engine_tb_top;
  localparam int N = 8;
  localparam int NV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic poly = 1'b0;
  logic [N*16-1:0] seed = '0;
  logic [N-1:0] valid = '0;
  logic [N*8-1:0] data = '0;
  logic [N*16-1:0] crc;
  logic [N-1:0] done;

  int n_tests = 0;
  int n_fail = 0;
  logic [15:0] model [N];
  logic [N-1:0] exp_done = '0;

  always #2.5 clk = ~clk;

  crc16_mc_engine #(.N_CH(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .seed_i(seed),
    .poly_sel_i(poly), .valid_i(valid), .data_i(data),
    .crc_o(crc), .done_o(done)
  );

  // {poly, seed, nbytes, bytes[72], expected}
  localparam logic [108:0] VEC [NV] = '{
    {1'b0, 16'hFFFF, 4'd9, 72'h313233343536373839, 16'h29B1},
    {1'b1, 16'h0000, 4'd9, 72'h313233343536373839, 16'hFEE8},
    {1'b0, 16'h0000, 4'd9, 72'h313233343536373839, 16'h31C3},
    {1'b1, 16'hFFFF, 4'd9, 72'h313233343536373839, 16'hAEE7},
    {1'b1, 16'h0000, 4'd3, 72'h0,                  16'h0000}
  };

  function automatic logic [15:0] ser(input logic [15:0] c, input logic [7:0] d, input logic p);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb = r[15] ^ d[b];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ (p ? 16'h8005 : 16'h1021);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, compare every channel at next negedge
  task automatic step(input logic [N-1:0] v, input logic [N*8-1:0] d, input logic clr, input string req);
    valid = v; data = d; clear = clr;
    for (int c = 0; c < N; c++) begin
      if (clr) model[c] = seed[c*16 +: 16];
      else if (v[c]) model[c] = ser(model[c], d[c*8 +: 8], poly);
    end
    exp_done = clr ? '0 : v;
    @(negedge clk);
    for (int c = 0; c < N; c++) chk(req, crc[c*16 +: 16], model[c]);
    chk("R8", {8'h0, done}, {8'h0, exp_done});
    valid = '0; clear = 1'b0;
  endtask

  function automatic logic [N*8-1:0] rnd_bytes();
    logic [N*8-1:0] r;
    for (int c = 0; c < N; c++) r[c*8 +: 8] = 8'($urandom);
    return r;
  endfunction

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < N; c++) begin
      model[c] = 16'hFFFF;
      chk("R1", crc[c*16 +: 16], 16'hFFFF);
    end
    chk("R1", {8'h0, done}, 16'h0);

    // table walk: known check values, all channels (R10, R3, R4, R5)
    for (int k = 0; k < NV; k++) begin
      poly = VEC[k][108];
      for (int c = 0; c < N; c++) seed[c*16 +: 16] = VEC[k][107:92];
      step('0, '0, 1'b1, "R2");
      for (int b = 0; b < int'(VEC[k][91:88]); b++)
        step('1, {N{VEC[k][87 - 8*b -: 8]}}, 1'b0, VEC[k][108] ? "R4" : "R3");
      for (int c = 0; c < N; c++) chk("R10", crc[c*16 +: 16], VEC[k][15:0]);
    end

    // R2: distinct seeds, clear beats valid
    for (int c = 0; c < N; c++) seed[c*16 +: 16] = 16'h1111 * 16'(c) ^ 16'hA5C3;
    step('1, rnd_bytes(), 1'b1, "R2");

    // R3/R5: back-to-back random bytes, CCITT
    poly = 1'b0;
    step('0, '0, 1'b0, "R6");
    for (int i = 0; i < 30; i++) step('1, rnd_bytes(), 1'b0, "R5");
    step('1, {N{8'h00}}, 1'b0, "R3");
    step('1, {N{8'hFF}}, 1'b0, "R3");

    // R9: switch generator while idle, continue without clear
    step('0, rnd_bytes(), 1'b0, "R6");
    poly = 1'b1;
    step('0, rnd_bytes(), 1'b0, "R9");
    for (int i = 0; i < 30; i++) step('1, rnd_bytes(), 1'b0, "R4");
    step('1, {N{8'hFF}}, 1'b0, "R4");
    step('1, {N{8'h00}}, 1'b0, "R4");

    // R6/R7: random masks, per-channel independence, both modes
    for (int m = 0; m < 2; m++) begin
      poly = m[0];
      step('0, '0, 1'b0, "R9");
      for (int i = 0; i < 40; i++) step(N'($urandom), rnd_bytes(), 1'b0, "R7");
    end
    step(8'b0000_0001, rnd_bytes(), 1'b0, "R7");
    step(8'b1000_0000, rnd_bytes(), 1'b0, "R6");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule